// File: doc/BRIEF.md
# Selectable Event Interrupt Controller

This block gathers eight event lines from transceiver logic and turns them into a single interrupt toward the MAC. Every event sets a sticky status flag as it occurs. A flag takes part in the interrupt only when the matching enable bit is set. The enables and the status flags share one 16-bit control/status word: the enables sit in the upper byte and the status flags in the lower byte. Reading that word returns both halves and empties the status flags.

A second register holds one bit that picks the active level of the interrupt pin, high or low. The pin is modelled as a tristate driver. The output-enable is high only while an enabled flag is pending; otherwise the pin is released. Software enables the events it cares about. When the pin goes active, software reads the control/status word to learn the cause and to clear it in the same access. An event that fires during that read is kept for the next read.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all enables, status flags and the polarity bit are 0, `irq_oe_o` is 0 and `rdata_o` is 0.
- R2: A write to address 0x11 (the control/status word) loads `wdata_i[8+k]` into the enable of event k, for k = 0..7. The new value is visible from the next cycle.
- R3: Bit 0 of address 0x12 is the polarity bit: 1 means active-high and 0 means active-low. Whenever `irq_oe_o` is 1, `irq_o` equals the polarity bit.
- R4: A read of 0x11 places {enables[15:8], status[7:0]} on `rdata_o` one cycle after the strobe. The same read clears every status flag.
- R5: Writes to bits 7:0 of 0x11 never change the status flags.
- R6: `irq_oe_o` is 1 exactly when at least one status flag is set while its enable is set. In every other state the pin is released.
- R7: An event that is high in the same cycle as a read of 0x11 is left set after the read. It does not appear in that read's returned data.
- R8: A disabled event still sets its status flag but does not raise `irq_oe_o`. Enabling it later raises `irq_oe_o` on the next cycle.
- R9: A read of 0x12 returns the polarity bit in bit 0 and zeros elsewhere. A read of any other address returns 0, and writes to other addresses have no effect. `rdata_o` holds its value between reads.
- R10: Status bit k becomes 1 the cycle after `evt_i[k]` is high, and stays 1 until a read of 0x11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event lines, one per source, sampled every cycle |
| addr_i | input | 5 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt level driven while enabled |
| irq_oe_o | output | 1 | Interrupt pin output-enable; 0 means high impedance |

## Verification
The bench builds the block with its default parameters: eight events, a 16-bit data word, and the two registers at 0x11 and 0x12. With these values the full enable byte and the full status byte can be driven and read back. Directed phases cover a read that collides with a new event, status-byte writes, disabled-event latching, and both pin polarities. A random phase follows in which reads, writes and events collide freely. A behavioural model is compared against the outputs on every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef struct packed {
    logic csr;
    logic cfg;
  } sel_t;

  function automatic sel_t decode(input logic [7:0] addr, input logic [7:0] csr_a,
                                  input logic [7:0] cfg_a);
    sel_t s;
    s.csr = (addr == csr_a);
    s.cfg = (addr == cfg_a);
    return s;
  endfunction
endpackage

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] status_o
);
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
    // a new event wins over the clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_o[k] <= 1'b0;
      else if (evt_i[k]) status_o[k] <= 1'b1;
      else if (clr_i)    status_o[k] <= 1'b0;
    end
  end

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i) |=> ((status_o & $past(status_o)) == $past(status_o)));
  a_r7_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> (status_o == '0));
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int         NUM_EVT  = 8,
  parameter int         DW       = 16,
  parameter int         AW       = 5,
  parameter logic [7:0] CSR_ADDR = 8'h11,
  parameter logic [7:0] CFG_ADDR = 8'h12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_EVT-1:0] status_i,
  output logic [NUM_EVT-1:0] en_o,
  output logic               pol_o,
  output logic               clr_o,
  output logic [DW-1:0]      rdata_o
);
  localparam int EN_LSB = DW / 2;

  sel_t          sel;
  logic [DW-1:0] rd_word;

  assign sel   = decode(8'(addr_i), CSR_ADDR, CFG_ADDR);
  assign clr_o = rd_i && sel.csr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      pol_o <= 1'b0;
    end else if (wr_i) begin
      if (sel.csr) en_o  <= wdata_i[EN_LSB +: NUM_EVT];
      if (sel.cfg) pol_o <= wdata_i[0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel.csr) begin
      rd_word[EN_LSB +: NUM_EVT] = en_o;
      rd_word[0 +: NUM_EVT]      = status_i;
    end else if (sel.cfg) begin
      rd_word[0] = pol_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_word;
  end

  a_r2_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel.csr) |=> (en_o == $past(wdata_i[EN_LSB +: NUM_EVT])));
  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i) |=> $stable(rdata_o));
endmodule

// File: rtl/evt_irq_pin.sv
module evt_irq_pin #(
  parameter int NUM_EVT = 8
) (
  input  logic [NUM_EVT-1:0] status_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic               pol_i,
  output logic               irq_o,
  output logic               irq_oe_o
);
  assign irq_oe_o = |(status_i & en_i);
  // level shown while released is the inactive one
  assign irq_o    = irq_oe_o ? pol_i : ~pol_i;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int         NUM_EVT  = 8,
  parameter int         DW       = 16,
  parameter int         AW       = 5,
  parameter logic [7:0] CSR_ADDR = 8'h11,
  parameter logic [7:0] CFG_ADDR = 8'h12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o,
  output logic               irq_oe_o
);
  logic [NUM_EVT-1:0] status, en;
  logic               pol, clr;

  evt_irq_regs #(
    .NUM_EVT(NUM_EVT), .DW(DW), .AW(AW), .CSR_ADDR(CSR_ADDR), .CFG_ADDR(CFG_ADDR)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i,
    .status_i(status), .en_o(en), .pol_o(pol), .clr_o(clr), .rdata_o
  );

  evt_irq_status #(.NUM_EVT(NUM_EVT)) i_status (
    .clk_i, .rst_ni, .evt_i, .clr_i(clr), .status_o(status)
  );

  evt_irq_pin #(.NUM_EVT(NUM_EVT)) i_pin (
    .status_i(status), .en_i(en), .pol_i(pol), .irq_o, .irq_oe_o
  );

  a_r3_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (irq_o == pol));
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & en) == '0) |-> !irq_oe_o);
  a_r5_status_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && evt_i == '0) |=> $stable(status));
  a_r8_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_oe_o);
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  localparam logic [4:0] CSR = 5'h11;
  localparam logic [4:0] CFG = 5'h12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic [4:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, irq_oe_o;

  always #4 clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk_i(clk), .rst_ni, .evt_i, .addr_i, .rd_i, .wr_i, .wdata_i,
    .rdata_o, .irq_o, .irq_oe_o
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  logic [7:0]  m_en, m_st;
  logic        m_pol;
  logic [15:0] m_rd;

  task automatic cmp(string t, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [7:0] nst;
    if (!rst_ni) begin
      m_en = '0; m_st = '0; m_pol = 1'b0; m_rd = '0;
      return;
    end
    if (rd_i) m_rd = (addr_i == CSR) ? {m_en, m_st} :
                     (addr_i == CFG) ? {15'b0, m_pol} : 16'h0;
    nst = ((rd_i && addr_i == CSR) ? 8'h0 : m_st) | evt_i;
    if (wr_i && addr_i == CSR) m_en  = wdata_i[15:8];
    if (wr_i && addr_i == CFG) m_pol = wdata_i[0];
    m_st = nst;
  endtask

  task automatic compare_all();
    logic oe;
    oe = |(m_st & m_en);
    cmp(tag, rdata_o, m_rd);
    cmp(tag, {15'b0, irq_oe_o}, {15'b0, oe});
    if (oe) cmp(tag, {15'b0, irq_o}, {15'b0, m_pol});
  endtask

  task automatic step(logic r, logic w, logic [4:0] a, logic [15:0] d, logic [7:0] e);
    @(negedge clk);
    model_step();
    compare_all();
    rd_i = r; wr_i = w; addr_i = a; wdata_i = d; evt_i = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'h0, 16'h0, 8'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_en = '0; m_st = '0; m_pol = 1'b0; m_rd = '0;
    tag = "R1";
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    step(1'b1, 1'b0, CSR, 16'h0, 8'h0);
    idle(1);
    cmp("R1", rdata_o, 16'h0);

    tag = "R10";
    step(1'b0, 1'b0, 5'h0, 16'h0, 8'h05);
    idle(4);
    step(1'b1, 1'b0, CSR, 16'h0, 8'h0);
    idle(1);
    cmp("R10", rdata_o, 16'h0005);

    tag = "R2";
    step(1'b0, 1'b1, CSR, 16'hA5FF, 8'h0);
    step(1'b1, 1'b0, CSR, 16'h0, 8'h0);
    idle(1);
    cmp("R2", rdata_o, 16'hA500);

    tag = "R5";
    step(1'b0, 1'b1, CSR, 16'hA5FF, 8'h0);
    idle(2);
    cmp("R5", {15'b0, irq_oe_o}, 16'h0);
    step(1'b1, 1'b0, CSR, 16'h0, 8'h0);
    idle(1);
    cmp("R5", rdata_o, 16'hA500);

    tag = "R8";
    step(1'b0, 1'b0, 5'h0, 16'h0, 8'h02);
    idle(2);
    cmp("R8", {15'b0, irq_oe_o}, 16'h0);
    step(1'b0, 1'b1, CSR, 16'h0200, 8'h0);
    idle(1);
    cmp("R8", {15'b0, irq_oe_o}, 16'h1);

    tag = "R3";
    cmp("R3", {15'b0, irq_o}, 16'h0);
    step(1'b0, 1'b1, CFG, 16'h0001, 8'h0);
    idle(1);
    cmp("R3", {15'b0, irq_o}, 16'h1);

    tag = "R7";
    step(1'b1, 1'b0, CSR, 16'h0, 8'h02);
    idle(1);
    cmp("R7", rdata_o, 16'h0202);
    cmp("R7", {15'b0, irq_oe_o}, 16'h1);
    step(1'b1, 1'b0, CSR, 16'h0, 8'h0);
    idle(1);
    cmp("R7", rdata_o, 16'h0202);
    cmp("R4", {15'b0, irq_oe_o}, 16'h0);

    tag = "R9";
    step(1'b1, 1'b0, CFG, 16'h0, 8'h0);
    idle(1);
    cmp("R9", rdata_o, 16'h0001);
    step(1'b0, 1'b1, 5'h03, 16'hFFFF, 8'h0);
    step(1'b1, 1'b0, 5'h03, 16'h0, 8'h0);
    idle(3);
    cmp("R9", rdata_o, 16'h0);

    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      a = ($urandom_range(0, 3) == 0) ? 5'($urandom) : ($urandom_range(0, 1) ? CSR : CFG);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0, a, 16'($urandom),
           ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'h0);
    end
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule